// File: doc/BRIEF.md
# Multipass Depth Layer Peeling Unit

This block picks out, for every pixel of one 32-wide by 16-high screen tile, the next surface to be composited in a strict front-to-back order. The same fragment stream for the tile is fed in once per pass. Two depths per pixel are held in flip-flops on chip. The first is the boundary already composited. The second is the nearest depth found so far behind that boundary in the current pass. Only fragments lying behind the boundary and nearer than the running candidate get through. They are forwarded to the compositor one cycle later.

At the end of a pass, each pixel that found something moves its boundary to that candidate. Its candidate then returns to the far plane. A pixel whose chosen surface was opaque with full coverage is marked finished, and it ignores every later fragment. The block raises a done flag once a pass ends with no pixel finding anything new, or once every pixel is finished. The controller then stops re-sending the stream.

Depths are 24-bit unsigned, and a smaller value is nearer. Legal fragment depths run from 1 to 0xFFFFFE. Value 0 is the initial boundary and 0xFFFFFF is the far plane. The pixel index is y*32 + x.

Top module: `depth_peel_unit`

## Requirements
- R1: During reset and in the first cycle after it, sel_valid and done are 0.
- R2: Inside a pass, a fragment whose depth is strictly greater than its pixel's composited depth and strictly less than its pixel's current candidate is forwarded. sel_valid is 1 and sel_x, sel_y, sel_depth, sel_opaque and sel_mask equal the fragment's fields in the cycle after it is presented.
- R3: A fragment whose depth is less than or equal to its pixel's composited depth is not forwarded.
- R4: A fragment whose depth is greater than or equal to its pixel's current candidate in the same pass is not forwarded.
- R5: After pass_end, every pixel that found a candidate takes that candidate as its composited depth. Its candidate returns to 0xFFFFFF for the next pass.
- R6: done is 1 in the cycle after a pass_end that closes a pass in which no pixel found a candidate. It is 0 in the cycle after any pass_start.
- R7: A pixel whose committed candidate came from a fragment with frag_opaque=1 and frag_mask=8'hFF is finished. No later fragment for it is forwarded until the next tile start.
- R8: done is 1 in the cycle after a pass_end that leaves all 512 pixels finished, even though candidates were found in that pass.
- R9: A fragment presented outside a pass (before any pass_start, or after pass_end) is not forwarded and changes no pixel state.
- R10: pass_start together with pass_first sets every composited depth to 0, every candidate to 0xFFFFFF, and clears every finished mark.
- R11: A fragment changes only the state of the pixel it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pass_start | input | 1 | Strobe opening a pass |
| pass_first | input | 1 | Qualifies pass_start as the first pass of a new tile |
| pass_end | input | 1 | Strobe closing the current pass |
| frag_valid | input | 1 | Fragment present this cycle |
| frag_x | input | 5 | Pixel column in tile |
| frag_y | input | 4 | Pixel row in tile |
| frag_depth | input | 24 | Fragment depth, smaller is nearer |
| frag_opaque | input | 1 | Fragment is opaque |
| frag_mask | input | 8 | Subpixel coverage mask |
| sel_valid | output | 1 | Forwarded fragment present |
| sel_x | output | 5 | Forwarded column |
| sel_y | output | 4 | Forwarded row |
| sel_depth | output | 24 | Forwarded depth |
| sel_opaque | output | 1 | Forwarded opacity flag |
| sel_mask | output | 8 | Forwarded coverage mask |
| done | output | 1 | No further pass is needed for this tile |

## Verification
A forwarded fragment appears on the sel outputs exactly one cycle after it is presented. The done flag settles one cycle after the pass_end or pass_start strobe. The bench drives every input on a falling edge and samples the outputs on the next falling edge, after the single register stage has updated. Because pixel state is written on the same edge, a fragment that follows immediately is judged against the new state. The table therefore checks back-to-back fragments to one pixel with no idle cycles.

// File: rtl/peel_pkg.sv
// Package: constants shared by the peeling unit and its bench.
// Assumes depth 0 is reserved as "before everything" and all-ones as far plane.
package peel_pkg;
    localparam int PEEL_X_W     = 5;
    localparam int PEEL_Y_W     = 4;
    localparam int PEEL_DEPTH_W = 24;
    localparam int PEEL_MASK_W  = 8;
endpackage

// File: rtl/peel_admit.sv
// Module: peel_admit
// Decides whether one fragment becomes its pixel's new candidate.
// Assumes stored depths are read combinationally for the same pixel.
module peel_admit #(
    parameter int DEPTH_W = 24
) (
    input  logic               in_pass,
    input  logic               frag_valid,
    input  logic               covered,
    input  logic [DEPTH_W-1:0] frag_depth,
    input  logic [DEPTH_W-1:0] committed,
    input  logic [DEPTH_W-1:0] cand,
    output logic               admit
);
    // Strictly behind the boundary and strictly nearer than the candidate.
    always_comb begin
        admit = in_pass && frag_valid && !covered &&
                (frag_depth > committed) && (frag_depth < cand);
    end
endmodule

// File: rtl/peel_layer_store.sv
// Module: peel_layer_store
// Holds two depth layers, a finished mark and a full-cover mark per pixel.
// Assumes at most one fragment update per cycle, never in a commit cycle.
module peel_layer_store #(
    parameter int IDX_W   = 9,
    parameter int DEPTH_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tile_init,
    input  logic               pass_commit,
    input  logic               upd_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DEPTH_W-1:0] upd_depth,
    input  logic               upd_full,
    output logic [DEPTH_W-1:0] rd_committed,
    output logic [DEPTH_W-1:0] rd_cand,
    output logic               rd_covered,
    output logic               any_found,
    output logic               all_covered_next
);
    localparam int NPIX = 1 << IDX_W;
    localparam logic [DEPTH_W-1:0] FAR = '1;

    logic [DEPTH_W-1:0] committed_q [NPIX];
    logic [DEPTH_W-1:0] cand_q      [NPIX];
    logic [NPIX-1:0]    covered_q;
    logic [NPIX-1:0]    full_q;
    logic [NPIX-1:0]    found_vec;

    // Read port for the addressed pixel.
    always_comb begin
        rd_committed = committed_q[idx];
        rd_cand      = cand_q[idx];
        rd_covered   = covered_q[idx];
    end

    // Per-pixel found flags and the tile-wide pass outcome.
    always_comb begin
        for (int i = 0; i < NPIX; i++) begin
            found_vec[i] = (cand_q[i] != FAR);
        end
        any_found        = |found_vec;
        all_covered_next = &(covered_q | (found_vec & full_q));
    end

    // State update: init, pass commit, or single fragment update.
    always_ff @(posedge clk) begin
        if (!rst_n || tile_init) begin
            for (int i = 0; i < NPIX; i++) begin
                committed_q[i] <= '0;
                cand_q[i]      <= FAR;
            end
            covered_q <= '0;
            full_q    <= '0;
        end else if (pass_commit) begin
            for (int i = 0; i < NPIX; i++) begin
                if (found_vec[i]) begin
                    committed_q[i] <= cand_q[i];
                    covered_q[i]   <= full_q[i];
                end
                cand_q[i] <= FAR;
            end
            full_q <= '0;
        end else if (upd_en) begin
            cand_q[idx] <= upd_depth;
            full_q[idx] <= upd_full;
        end
    end

    // R5: after a commit every candidate is back at the far plane.
    a_r5_cand_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pass_commit) && !$past(tile_init) |-> !any_found);

    // R11: a fragment update never touches the finished marks.
    a_r11_covered_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(upd_en) && !$past(pass_commit) && !$past(tile_init) |->
        $stable(covered_q));
endmodule

// File: rtl/depth_peel_unit.sv
// Module: depth_peel_unit
// Front-to-back layer peeling for one tile across repeated fragment passes.
// Assumes pass_end and fragments never share a cycle, and legal depths are
// 1 .. 2**DEPTH_W-2.
module depth_peel_unit
    import peel_pkg::*;
#(
    parameter int X_W     = PEEL_X_W,
    parameter int Y_W     = PEEL_Y_W,
    parameter int DEPTH_W = PEEL_DEPTH_W,
    parameter int MASK_W  = PEEL_MASK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pass_start,
    input  logic               pass_first,
    input  logic               pass_end,
    input  logic               frag_valid,
    input  logic [X_W-1:0]     frag_x,
    input  logic [Y_W-1:0]     frag_y,
    input  logic [DEPTH_W-1:0] frag_depth,
    input  logic               frag_opaque,
    input  logic [MASK_W-1:0]  frag_mask,
    output logic               sel_valid,
    output logic [X_W-1:0]     sel_x,
    output logic [Y_W-1:0]     sel_y,
    output logic [DEPTH_W-1:0] sel_depth,
    output logic               sel_opaque,
    output logic [MASK_W-1:0]  sel_mask,
    output logic               done
);
    localparam int IDX_W = X_W + Y_W;

    logic               in_pass;
    logic               admit;
    logic               tile_init;
    logic               pass_commit;
    logic [IDX_W-1:0]   idx;
    logic [DEPTH_W-1:0] rd_committed;
    logic [DEPTH_W-1:0] rd_cand;
    logic               rd_covered;
    logic               any_found;
    logic               all_covered_next;

    // Control strobes and pixel address.
    always_comb begin
        idx         = {frag_y, frag_x};
        tile_init   = pass_start && pass_first;
        pass_commit = pass_end && in_pass && !pass_start;
    end

    peel_layer_store #(.IDX_W(IDX_W), .DEPTH_W(DEPTH_W)) u_store (
        .clk              (clk),
        .rst_n            (rst_n),
        .tile_init        (tile_init),
        .pass_commit      (pass_commit),
        .upd_en           (admit),
        .idx              (idx),
        .upd_depth        (frag_depth),
        .upd_full         (frag_opaque && (&frag_mask)),
        .rd_committed     (rd_committed),
        .rd_cand          (rd_cand),
        .rd_covered       (rd_covered),
        .any_found        (any_found),
        .all_covered_next (all_covered_next)
    );

    peel_admit #(.DEPTH_W(DEPTH_W)) u_admit (
        .in_pass    (in_pass && !pass_start),
        .frag_valid (frag_valid),
        .covered    (rd_covered),
        .frag_depth (frag_depth),
        .committed  (rd_committed),
        .cand       (rd_cand),
        .admit      (admit)
    );

    // Pass window tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)          in_pass <= 1'b0;
        else if (pass_start) in_pass <= 1'b1;
        else if (pass_end)   in_pass <= 1'b0;
    end

    // Done flag: decided at pass end, withdrawn at pass start.
    always_ff @(posedge clk) begin
        if (!rst_n || pass_start) done <= 1'b0;
        else if (pass_commit)     done <= !any_found || all_covered_next;
    end

    // Registered forward path to the compositor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid  <= 1'b0;
            sel_x      <= '0;
            sel_y      <= '0;
            sel_depth  <= '0;
            sel_opaque <= 1'b0;
            sel_mask   <= '0;
        end else begin
            sel_valid  <= admit;
            sel_x      <= frag_x;
            sel_y      <= frag_y;
            sel_depth  <= frag_depth;
            sel_opaque <= frag_opaque;
            sel_mask   <= frag_mask;
        end
    end

    // R1: outputs idle in the first cycle out of reset.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sel_valid && !done));

    // R2: a forwarded fragment is the one presented a cycle earlier.
    a_r2_forward_match: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> ($past(frag_valid) && sel_depth == $past(frag_depth)));

    // R9: nothing is forwarded unless a pass was open.
    a_r9_only_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> $past(in_pass));

    // R6: done only rises right after a pass end.
    a_r6_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(pass_end));

    // R6: pass start withdraws done.
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pass_start) && $past(rst_n) |-> !done);
endmodule

// File: tb/depth_peel_unit_tb.sv
module depth_peel_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pass_start = 1'b0, pass_first = 1'b0, pass_end = 1'b0;
    logic        frag_valid = 1'b0;
    logic [4:0]  frag_x = '0;
    logic [3:0]  frag_y = '0;
    logic [23:0] frag_depth = '0;
    logic        frag_opaque = 1'b0;
    logic [7:0]  frag_mask = '0;
    logic        sel_valid, sel_opaque, done;
    logic [4:0]  sel_x;
    logic [3:0]  sel_y;
    logic [23:0] sel_depth;
    logic [7:0]  sel_mask;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    depth_peel_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .pass_first(pass_first),
        .pass_end(pass_end), .frag_valid(frag_valid), .frag_x(frag_x), .frag_y(frag_y),
        .frag_depth(frag_depth), .frag_opaque(frag_opaque), .frag_mask(frag_mask),
        .sel_valid(sel_valid), .sel_x(sel_x), .sel_y(sel_y), .sel_depth(sel_depth),
        .sel_opaque(sel_opaque), .sel_mask(sel_mask), .done(done)
    );

    // ops: 0 fragment, 1 pass start, 2 first pass start, 3 pass end
    // fields: op[44:43] x[42:38] y[37:34] depth[33:10] opaque[9] mask[8:1] exp[0]
    localparam int NV = 20;
    localparam logic [44:0] VEC [NV] = '{
        {2'd2, 5'd0, 4'd0, 24'd0,   1'b0, 8'h00, 1'b0},  // R10 tile start
        {2'd0, 5'd1, 4'd1, 24'd100, 1'b0, 8'h0F, 1'b1},  // R2
        {2'd0, 5'd1, 4'd1, 24'd200, 1'b0, 8'h0F, 1'b0},  // R4 farther
        {2'd0, 5'd1, 4'd1, 24'd50,  1'b1, 8'h3C, 1'b1},  // R2 nearer
        {2'd0, 5'd1, 4'd1, 24'd50,  1'b0, 8'h01, 1'b0},  // R4 equal
        {2'd0, 5'd2, 4'd1, 24'd300, 1'b0, 8'h11, 1'b1},  // R11 neighbour
        {2'd3, 5'd0, 4'd0, 24'd0,   1'b0, 8'h00, 1'b0},  // R5 end, found
        {2'd1, 5'd0, 4'd0, 24'd0,   1'b0, 8'h00, 1'b0},
        {2'd0, 5'd1, 4'd1, 24'd50,  1'b0, 8'h0F, 1'b0},  // R3 equal boundary
        {2'd0, 5'd1, 4'd1, 24'd40,  1'b0, 8'h0F, 1'b0},  // R3 nearer
        {2'd0, 5'd1, 4'd1, 24'd100, 1'b0, 8'h0F, 1'b1},  // R5 next layer
        {2'd0, 5'd2, 4'd1, 24'd300, 1'b0, 8'h11, 1'b0},  // R3 at boundary
        {2'd0, 5'd2, 4'd1, 24'd400, 1'b1, 8'hFF, 1'b1},  // R7 full opaque
        {2'd3, 5'd0, 4'd0, 24'd0,   1'b0, 8'h00, 1'b0},
        {2'd1, 5'd0, 4'd0, 24'd0,   1'b0, 8'h00, 1'b0},
        {2'd0, 5'd2, 4'd1, 24'd500, 1'b0, 8'h01, 1'b0},  // R7 finished pixel
        {2'd0, 5'd1, 4'd1, 24'd200, 1'b0, 8'h0F, 1'b1},  // R2
        {2'd3, 5'd0, 4'd0, 24'd0,   1'b0, 8'h00, 1'b0},
        {2'd1, 5'd0, 4'd0, 24'd0,   1'b0, 8'h00, 1'b0},
        {2'd3, 5'd0, 4'd0, 24'd0,   1'b0, 8'h00, 1'b1}   // R6 empty pass
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one operation for a cycle; outputs are sampled one edge later.
    task automatic apply(input logic [1:0] op, input logic [4:0] x, input logic [3:0] y,
                         input logic [23:0] d, input logic o, input logic [7:0] m);
        frag_valid  = (op == 2'd0);
        pass_start  = (op == 2'd1) || (op == 2'd2);
        pass_first  = (op == 2'd2);
        pass_end    = (op == 2'd3);
        frag_x = x; frag_y = y; frag_depth = d; frag_opaque = o; frag_mask = m;
        @(negedge clk);
        frag_valid = 1'b0; pass_start = 1'b0; pass_first = 1'b0; pass_end = 1'b0;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!sel_valid && !done, "R1 in reset", int'({sel_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sel_valid && !done, "R1 after reset", int'({sel_valid, done}), 0);

        // R9: fragment before any pass
        apply(2'd0, 5'd3, 4'd2, 24'd10, 1'b0, 8'h01);
        check(!sel_valid, "R9 before pass", int'(sel_valid), 0);

        for (int i = 0; i < NV; i++) begin
            logic [44:0] v;
            v = VEC[i];
            apply(v[44:43], v[42:38], v[37:34], v[33:10], v[9], v[8:1]);
            if (v[44:43] == 2'd0) begin
                check(sel_valid == v[0], "R2/R3/R4/R5/R7/R11 sel_valid", int'(sel_valid), int'(v[0]));
                if (v[0])
                    check(sel_depth == v[33:10] && sel_x == v[42:38] && sel_y == v[37:34]
                          && sel_opaque == v[9] && sel_mask == v[8:1],
                          "R2 fields", int'(sel_depth), int'(v[33:10]));
            end else if (v[44:43] == 2'd3) begin
                check(done == v[0], "R6 done at pass end", int'(done), int'(v[0]));
            end else begin
                check(!done, "R6 start clears done", int'(done), 0);
            end
        end

        // R9: fragment after pass end (pixel 3,2 still unpeeled)
        apply(2'd0, 5'd3, 4'd2, 24'd10, 1'b0, 8'h01);
        check(!sel_valid, "R9 after pass end", int'(sel_valid), 0);
        apply(2'd1, 5'd0, 4'd0, 24'd0, 1'b0, 8'h00);
        check(!done, "R6 cleared by start", int'(done), 0);
        apply(2'd0, 5'd3, 4'd2, 24'd20, 1'b0, 8'h01);
        check(sel_valid, "R9 state untouched", int'(sel_valid), 1);
        apply(2'd0, 5'd3, 4'd2, 24'd10, 1'b0, 8'h01);
        check(sel_valid, "R9 earlier fragment left no candidate", int'(sel_valid), 1);
        apply(2'd3, 5'd0, 4'd0, 24'd0, 1'b0, 8'h00);
        check(!done, "R6 found means not done", int'(done), 0);

        // R10: new tile resets finished pixel (2,1) and its boundary
        apply(2'd2, 5'd0, 4'd0, 24'd0, 1'b0, 8'h00);
        apply(2'd0, 5'd2, 4'd1, 24'd1, 1'b0, 8'h01);
        check(sel_valid, "R10 nearest legal depth admitted", int'(sel_valid), 1);
        apply(2'd3, 5'd0, 4'd0, 24'd0, 1'b0, 8'h00);

        // R8: every pixel gets a full opaque fragment in one pass
        apply(2'd2, 5'd0, 4'd0, 24'd0, 1'b0, 8'h00);
        for (int p = 0; p < 512; p++)
            apply(2'd0, p[4:0], p[8:5], 24'd10, 1'b1, 8'hFF);
        apply(2'd3, 5'd0, 4'd0, 24'd0, 1'b0, 8'h00);
        check(done, "R8 all pixels finished", int'(done), 1);
        apply(2'd1, 5'd0, 4'd0, 24'd0, 1'b0, 8'h00);
        apply(2'd0, 5'd7, 4'd9, 24'd50, 1'b1, 8'hFF);
        check(!sel_valid, "R7 finished pixel ignores behind", int'(sel_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule